// File: doc/BRIEF.md
# Compressed Instruction Mode Tracker

This block sits on the fetch side of a processor front end. It takes an aligned stream of 16-bit halfwords in which standard 32-bit instructions are mixed with 10-bit and 16-bit compressed instructions. For each instruction it emits one tagged item: a kind code and the raw instruction bits. A 32-bit instruction is put together from two consecutive halfwords. Compressed instructions occupy one halfword each.

The encoding mode is tracked internally and changed in-band. A halfword whose five most significant bits equal a reserved entry value starts compressed coding with a 10-bit instruction. The least significant bit of that halfword selects what follows. In 16-bit mode, the most and least significant bits of every halfword form a two-bit continuation code. One of the codes lets exactly one 32-bit instruction through and then returns to 16-bit mode with no new entry halfword.

Both sides use a valid/ready handshake. The block does not decode what an instruction means, and it does not handle redirects or flushes.

Top module: `cmode_tracker`

## Requirements
- R1: After reset the tracker is in 32-bit mode, holds no partial word, and has out_valid low. A halfword accepted before reset is never merged with halfwords accepted after it.
- R2: In 32-bit mode, an instruction that does not start with the entry value takes two halfwords. The first accepted halfword is held and produces no output. On acceptance of the second, one item is emitted with kind 0 (32-bit) and out_bits = {first, second}.
- R3: In 32-bit mode, a halfword that starts an instruction and has bits [15:11] equal to ENTRY_OP is emitted alone with kind 1 (10-bit) and out_bits = {16'h0, halfword}. This applies even though the block is already in 32-bit mode. The second halfword of a 32-bit pair is never treated as an entry, whatever its top bits are.
- R4: After a 10-bit item, a halfword bit 0 of 0 keeps 32-bit mode. A bit 0 of 1 enters 16-bit mode.
- R5: In 16-bit mode every halfword is one item with out_bits = {16'h0, halfword}, whatever its top bits are. Its continuation code is {bit 15, bit 0}. Code 01 gives kind 2 (16-bit) and stays in 16-bit mode.
- R6: Code 00 gives kind 2 and returns to 32-bit mode permanently.
- R7: Code 10 gives kind 2. The next two halfwords form one 32-bit item, with no entry recognition in that item, and then 16-bit mode resumes.
- R8: Code 11 gives kind 3 (alternate immediate-format 16-bit) and stays in 16-bit mode.
- R9: in_ready equals out_ready. While out_valid is high and out_ready is low, out_valid, out_kind and out_bits hold steady.
- R10: Items leave in input order. No halfword is dropped or duplicated, and out_valid is low in a cycle after a transfer unless a new item was produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword accepted when high together with in_valid |
| in_half | input | HALF_W | Incoming halfword |
| out_valid | output | 1 | Item available |
| out_ready | input | 1 | Downstream takes the item |
| out_kind | output | 2 | 0 = 32-bit, 1 = 10-bit, 2 = 16-bit, 3 = alternate 16-bit |
| out_bits | output | 2*HALF_W | Raw instruction bits, zero-extended for compressed items |

## Verification
The bench targets the one-shot 32-bit slot after code 10. A design that forgot to return to 16-bit mode would treat the following halfwords as pairs. A design that recognised the entry value inside that slot would split the pair. It also places the entry value in the second half of a pair and inside 16-bit mode, where a wrong design would emit spurious 10-bit items. It resets while a first halfword is held, and a design that kept the partial word would emit a corrupted merged instruction. All sequences are repeated under irregular backpressure to catch dropped, duplicated or changing items.

// File: rtl/cmode_pkg.sv
package cmode_pkg;
  typedef enum logic [1:0] {
    K_W32  = 2'd0,
    K_C10  = 2'd1,
    K_C16  = 2'd2,
    K_ALT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    M_W32  = 2'd0,
    M_C16  = 2'd1,
    M_ONCE = 2'd2
  } mode_e;
endpackage

// File: rtl/cmode_classify.sv
module cmode_classify
  import cmode_pkg::*;
#(
  parameter int          OP_W     = 5,
  parameter logic [OP_W-1:0] ENTRY_OP = 5'b11110
) (
  input  mode_e           mode,
  input  logic            held,
  input  logic [OP_W-1:0] op_field,
  input  logic            first_bit,
  input  logic            last_bit,
  output logic            emit,
  output kind_e           kind,
  output logic            take_hold,
  output mode_e           next_mode
);
  logic [1:0] code;
  assign code = {first_bit, last_bit};

  always_comb begin
    emit      = 1'b0;
    kind      = K_W32;
    take_hold = 1'b0;
    next_mode = mode;
    if (mode == M_C16) begin
      emit = 1'b1;
      kind = (code == 2'b11) ? K_ALT : K_C16;
      case (code)
        2'b00:   next_mode = M_W32;
        2'b10:   next_mode = M_ONCE;
        default: next_mode = M_C16;
      endcase
    end else if (held) begin
      emit      = 1'b1;
      kind      = K_W32;
      next_mode = (mode == M_ONCE) ? M_C16 : M_W32;
    end else if (mode == M_W32 && op_field == ENTRY_OP) begin
      emit      = 1'b1;
      kind      = K_C10;
      next_mode = last_bit ? M_C16 : M_W32;
    end else begin
      take_hold = 1'b1;
    end
  end
endmodule

// File: rtl/cmode_state.sv
module cmode_state
  import cmode_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              acc,
  input  logic              take_hold,
  input  mode_e             next_mode,
  input  logic [HALF_W-1:0] half,
  output mode_e             mode_q,
  output logic              held_q,
  output logic [HALF_W-1:0] hold_q
);
  mode_e             mode_d;
  logic              held_d;
  logic [HALF_W-1:0] hold_d;

  always_comb begin
    mode_d = mode_q;
    held_d = held_q;
    hold_d = hold_q;
    if (acc) begin
      mode_d = next_mode;
      held_d = take_hold;
      if (take_hold) hold_d = half;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_W32;
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (acc) begin
      mode_q <= mode_d;
      held_q <= held_d;
      hold_q <= hold_d;
    end
  end

  // R5: a pair is never open while every halfword is its own item
  assert_no_pair_in16_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mode_q == M_C16 && held_q));

  // R6: exit code returns to 32-bit mode
  assert_exit_code_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && mode_q == M_C16 && !half[HALF_W-1] && !half[0]) |=> (mode_q == M_W32));

  // R7: the one-shot slot ends back in 16-bit mode
  assert_once_return_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && mode_q == M_ONCE && held_q) |=> (mode_q == M_C16 && !held_q));

  // R8: alternate code keeps 16-bit mode
  assert_alt_stays_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && mode_q == M_C16 && half[HALF_W-1] && half[0]) |=> (mode_q == M_C16));
endmodule

// File: rtl/cmode_outreg.sv
module cmode_outreg
  import cmode_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  kind_e             kind,
  input  logic [WORD_W-1:0] bits,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [WORD_W-1:0] out_bits
);
  logic              valid_d;
  logic [1:0]        kind_d;
  logic [WORD_W-1:0] bits_d;

  always_comb begin
    valid_d = load;
    kind_d  = load ? kind : out_kind;
    bits_d  = load ? bits : out_bits;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_bits  <= '0;
    end else if (out_ready) begin
      out_valid <= valid_d;
      out_kind  <= kind_d;
      out_bits  <= bits_d;
    end
  end

  // R9: a stalled item stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_bits)));

  // R10: an item that left is not repeated unless new input was taken
  assert_no_dup_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_ready && !load) |=> !out_valid);
endmodule

// File: rtl/cmode_tracker.sv
module cmode_tracker
  import cmode_pkg::*;
#(
  parameter int              HALF_W   = 16,
  parameter int              OP_W     = 5,
  parameter logic [OP_W-1:0] ENTRY_OP = 5'b11110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [HALF_W-1:0]   in_half,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_kind,
  output logic [2*HALF_W-1:0] out_bits
);
  localparam int WORD_W = 2 * HALF_W;

  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic              acc, emit, take_hold, held_q;
  kind_e             kind;
  mode_e             mode_q, next_mode;
  logic [HALF_W-1:0] hold_q;
  logic [WORD_W-1:0] item_bits;

  assign in_ready = out_ready;
  assign acc      = in_valid && in_ready;

  cmode_classify #(.OP_W(OP_W), .ENTRY_OP(ENTRY_OP)) u_classify (
    .mode      (mode_q),
    .held      (held_q),
    .op_field  (in_half[HALF_W-1 -: OP_W]),
    .first_bit (in_half[HALF_W-1]),
    .last_bit  (in_half[0]),
    .emit      (emit),
    .kind      (kind),
    .take_hold (take_hold),
    .next_mode (next_mode)
  );

  cmode_state #(.HALF_W(HALF_W)) u_state (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .acc       (acc),
    .take_hold (take_hold),
    .next_mode (next_mode),
    .half      (in_half),
    .mode_q    (mode_q),
    .held_q    (held_q),
    .hold_q    (hold_q)
  );

  assign item_bits = (kind == K_W32) ? {hold_q, in_half} : {{HALF_W{1'b0}}, in_half};

  cmode_outreg #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .load      (acc && emit),
    .kind      (kind),
    .bits      (item_bits),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_bits  (out_bits)
  );

  // R2: a 32-bit item only follows an accepted closing halfword
  assert_pair_closed_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_ready && $rose(out_valid) && out_kind == 2'd0) |-> $past(acc && held_q));
endmodule

// File: tb/cmode_tracker_test.sv
module cmode_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [31:0] out_bits;

  int checks = 0;
  int errors = 0;
  bit stall_en = 0;
  bit done = 0;
  int cyc = 0;

  logic [1:0]  exp_kind[$];
  logic [31:0] exp_bits[$];
  string       exp_tag[$];

  cmode_tracker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_bits(out_bits)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready = stall_en ? (cyc[0] ^ cyc[2]) : 1'b1;
  end

  // monitor: sample at negedge, a transfer completes at the next posedge
  logic        was_stalled = 0;
  logic [1:0]  st_kind;
  logic [31:0] st_bits;
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== out_ready) begin
        errors++;
        $display("FAIL R9 in_ready=%b expected %b", in_ready, out_ready);
      end
      if (was_stalled) begin
        checks++;
        if (out_valid !== 1'b1 || out_kind !== st_kind || out_bits !== st_bits) begin
          errors++;
          $display("FAIL R9 stalled item changed: %0d/%h expected %0d/%h",
                   out_kind, out_bits, st_kind, st_bits);
        end
      end
      was_stalled = out_valid && !out_ready;
      st_kind = out_kind;
      st_bits = out_bits;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_kind.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected item %0d/%h expected none", out_kind, out_bits);
        end else begin
          if (out_kind !== exp_kind[0] || out_bits !== exp_bits[0]) begin
            errors++;
            $display("FAIL %s got %0d/%h expected %0d/%h", exp_tag[0],
                     out_kind, out_bits, exp_kind[0], exp_bits[0]);
          end
          void'(exp_kind.pop_front());
          void'(exp_bits.pop_front());
          void'(exp_tag.pop_front());
        end
      end
    end else begin
      was_stalled = 0;
    end
  end

  task automatic expect_item(input logic [1:0] k, input logic [31:0] b, input string tag);
    exp_kind.push_back(k);
    exp_bits.push_back(b);
    exp_tag.push_back(tag);
  endtask

  task automatic send(input logic [15:0] h);
    in_valid = 1'b1;
    in_half  = h;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_kind.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic run_seq();
    // R1, R2: plain pair
    expect_item(2'd0, 32'h12345678, "R2 pair");
    send(16'h1234); send(16'h5678);
    // R3: entry value in second half is data
    expect_item(2'd0, 32'h0001F000, "R3 second half not entry");
    send(16'h0001); send(16'hF000);
    // R3, R4: entry with bit0=0 stays in 32-bit mode
    expect_item(2'd1, 32'h0000F0AA, "R3 entry M0");
    send(16'hF0AA);
    expect_item(2'd0, 32'hAAAABBBB, "R4 stays 32");
    send(16'hAAAA); send(16'hBBBB);
    // R4: entry with bit0=1 enters 16-bit mode
    expect_item(2'd1, 32'h0000F155, "R4 entry M1");
    send(16'hF155);
    expect_item(2'd2, 32'h00000123, "R5 code01");
    send(16'h0123);
    expect_item(2'd3, 32'h00008001, "R8 code11");
    send(16'h8001);
    expect_item(2'd3, 32'h0000F001, "R5 entry value inside 16-bit mode");
    send(16'hF001);
    expect_item(2'd2, 32'h00000F01, "R8 stayed 16");
    send(16'h0F01);
    expect_item(2'd2, 32'h00008A02, "R7 code10");
    send(16'h8A02);
    expect_item(2'd0, 32'hF00D1111, "R7 one-shot pair");
    send(16'hF00D); send(16'h1111);
    expect_item(2'd2, 32'h00004445, "R7 back in 16");
    send(16'h4445);
    expect_item(2'd2, 32'h00002222, "R6 code00");
    send(16'h2222);
    expect_item(2'd0, 32'hCAFEBEEF, "R6 back in 32");
    send(16'hCAFE); send(16'hBEEF);
    drain();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_valid=%b expected 0 after reset", out_valid);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    do_reset();
    run_seq();
    stall_en = 1;
    run_seq();
    stall_en = 0;
    // R1: a partial word before reset is discarded
    send(16'h1234);
    repeat (3) @(posedge clk);
    #1;
    do_reset();
    expect_item(2'd0, 32'h0BAD0C0D, "R1 no partial word kept");
    send(16'h0BAD); send(16'h0C0D);
    drain();
    checks++;
    if (exp_kind.size() != 0) begin
      errors++;
      $display("FAIL R10 %0d items missing expected 0", exp_kind.size());
    end
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      finish_run();
    end
  end
endmodule